// File: doc/BRIEF.md
# Preemptive Circuit Crossbar Allocator

This block hands out input-to-output pairings for a circuit-switched crossbar with a fixed number of ports. Each cycle any input can present a connection request. The request names a target output and carries a priority. The allocator answers in one of three ways:

- It grants a free output and forwards the request on that output.
- It reflects a refusal (NACK) back to the requesting input.
- If the requester outranks the current holder, it emits a preempt token toward the holder's output and parks the requester until that connection is torn down.

Teardown happens when a done token arrives on an output. The done token is returned to the input that owned the output, and the pairing is released. If a preemptor is parked on that output, it takes the output over in the same cycle.

Each output can name one alternate output. When the requested output is occupied, the allocator walks this chain of alternates from the named port and takes the first free one. The walk is capped at the port count, so a circular chain always ends. When several inputs compete in one cycle, they are served in ascending index order.

Top module: `xbar_preempt_alloc`

## Requirements
- R1: A request from an idle input whose named output is unowned produces a forwarded request one cycle later on that output (`fwd_valid`=1, `fwd_preempt`=0, `fwd_src`=requesting input), and the output becomes owned by that input.
- R2: A request whose named output is owned, whose alternate chain holds no free output and which cannot preempt gets `back_nack` one cycle later and changes no ownership.
- R3: When the named output is owned, the allocator follows `alt_to` while `alt_en` of the current port is set, for at most NPORTS ports including the named one, and grants the first unowned port met; a disabled link ends the walk.
- R4: A done token on an owned output raises `back_done` on the owning input one cycle later and frees the output for requests from the following cycle; a done token on an unowned output has no effect.
- R5: A request that finds no free port, whose priority is strictly greater than the holder of its named output, and whose output has an empty pending slot, emits a preempt token one cycle later on that output (`fwd_preempt`=1, `fwd_src`=holder input) and gets no NACK.
- R6: A blocked request with priority equal to or lower than the holder, or one whose named output already has a pending preemptor, is NACKed.
- R7: When a done token releases an output with a pending preemptor, the same cycle that returns `back_done` to the old holder forwards a request on that output with `fwd_src` set to the preemptor, which becomes the new owner.
- R8: Requests in one cycle are resolved in ascending input index order; an output granted to a lower index is seen as owned by every higher index in that cycle.
- R9: An input that holds a connection or is waiting as a preemptor has any further request NACKed.
- R10: An output receiving a done token in a cycle counts as owned and not preemptible for requests in that same cycle.
- R11: After reset all outputs are 0 and every port is unowned; no token appears on any port except as the rules above call for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORTS | Request present on each input |
| req_port | input | NPORTS*IDX_W | Named output per input, field i at bits [i*IDX_W +: IDX_W] |
| req_prio | input | NPORTS*PRIO_W | Priority per input, larger outranks |
| done_valid | input | NPORTS | Done token arriving on each output |
| alt_en | input | NPORTS | Output has an alternate link |
| alt_to | input | NPORTS*IDX_W | Alternate output for each output |
| fwd_valid | output | NPORTS | Token leaving each output |
| fwd_preempt | output | NPORTS | 1 = preempt token, 0 = forwarded request |
| fwd_src | output | NPORTS*IDX_W | Input index the token belongs to |
| back_nack | output | NPORTS | NACK returned to each input |
| back_done | output | NPORTS | Done returned to each input |

## Verification
Every result — grant, NACK, preempt token, returned done and takeover — is registered once, so it appears exactly one cycle after the clock edge that samples the stimulus. Ownership changes made at that edge are visible to requests in the next cycle.

The bench drives inputs just after a rising edge. It lets a behavioural model compute that cycle's expected tokens from the same inputs and the model's own ownership tables. After the next edge it compares every output port against the expectation, then applies the model's state update. Directed sequences cover contention, circular chains, same-cycle release and takeover; a long random phase follows.

// File: rtl/xbar_alloc_pkg.sv
package xbar_alloc_pkg;
  typedef enum logic {
    TOK_REQUEST = 1'b0,
    TOK_PREEMPT = 1'b1
  } fwd_kind_e;
endpackage

// File: rtl/xbar_port_slot.sv
module xbar_port_slot #(
  parameter int IDX_W  = 3,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant,
  input  logic [IDX_W-1:0]  grant_in,
  input  logic [PRIO_W-1:0] grant_prio,
  input  logic              pre_set,
  input  logic [IDX_W-1:0]  pre_in,
  input  logic [PRIO_W-1:0] pre_prio,
  input  logic              release_i,
  output logic              own_v,
  output logic [IDX_W-1:0]  own_in,
  output logic [PRIO_W-1:0] own_prio,
  output logic              pend_v,
  output logic [IDX_W-1:0]  pend_in
);
  logic [PRIO_W-1:0] pend_prio;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_v     <= 1'b0;
      own_in    <= '0;
      own_prio  <= '0;
      pend_v    <= 1'b0;
      pend_in   <= '0;
      pend_prio <= '0;
    end else begin
      if (release_i) begin
        if (pend_v) begin
          own_in   <= pend_in;
          own_prio <= pend_prio;
          pend_v   <= 1'b0;
        end else begin
          own_v <= 1'b0;
        end
      end else if (grant) begin
        own_v    <= 1'b1;
        own_in   <= grant_in;
        own_prio <= grant_prio;
      end
      if (pre_set) begin
        pend_v    <= 1'b1;
        pend_in   <= pre_in;
        pend_prio <= pre_prio;
      end
    end
  end

  // R1: a grant only lands on an unowned port
  a_r1_grant_only_free: assert property (@(posedge clk) disable iff (rst)
    grant |-> !own_v);
  // R10: a releasing port is never granted or preempted in the same cycle
  a_r10_release_exclusive: assert property (@(posedge clk) disable iff (rst)
    release_i |-> !grant && !pre_set);
  // R5: preemption needs a holder, an empty slot and strictly higher priority
  a_r5_preempt_outranks: assert property (@(posedge clk) disable iff (rst)
    pre_set |-> own_v && !pend_v && (pre_prio > own_prio));
  // R7: takeover passes ownership to the parked preemptor
  a_r7_handoff: assert property (@(posedge clk) disable iff (rst)
    (release_i && pend_v) |=> own_v && !pend_v && (own_in == $past(pend_in)));
  // R4: release without preemptor frees the port
  a_r4_release_frees: assert property (@(posedge clk) disable iff (rst)
    (release_i && !pend_v) |=> !own_v);
  // R6: a pending slot only exists under a holder
  a_r6_pend_has_owner: assert property (@(posedge clk) disable iff (rst)
    pend_v |-> own_v);
endmodule

// File: rtl/xbar_input_ctl.sv
module xbar_input_ctl (
  input  logic clk,
  input  logic rst,
  input  logic grant,
  input  logic wait_set,
  input  logic handoff,
  input  logic done_back,
  output logic busy
);
  logic conn_q;
  logic wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      conn_q <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      if (grant || handoff) conn_q <= 1'b1;
      else if (done_back)   conn_q <= 1'b0;
      if (wait_set)         wait_q <= 1'b1;
      else if (handoff)     wait_q <= 1'b0;
    end
  end

  assign busy = conn_q | wait_q;

  // R9: an input is never connected and waiting at once
  a_r9_conn_wait_excl: assert property (@(posedge clk) disable iff (rst)
    !(conn_q && wait_q));
  // R9: the grant logic never serves a busy input
  a_r9_no_serve_busy: assert property (@(posedge clk) disable iff (rst)
    (grant || wait_set) |-> !busy);
endmodule

// File: rtl/xbar_grant_logic.sv
module xbar_grant_logic #(
  parameter int NPORTS = 8,
  parameter int IDX_W  = 3,
  parameter int PRIO_W = 3
) (
  input  logic [NPORTS-1:0]        req_valid,
  input  logic [NPORTS*IDX_W-1:0]  req_port,
  input  logic [NPORTS*PRIO_W-1:0] req_prio,
  input  logic [NPORTS-1:0]        in_busy,
  input  logic [NPORTS-1:0]        own_v,
  input  logic [NPORTS*PRIO_W-1:0] own_prio,
  input  logic [NPORTS-1:0]        pend_v,
  input  logic [NPORTS-1:0]        releasing,
  input  logic [NPORTS-1:0]        alt_en,
  input  logic [NPORTS*IDX_W-1:0]  alt_to,
  output logic [NPORTS-1:0]        grant_v,
  output logic [NPORTS*IDX_W-1:0]  grant_in,
  output logic [NPORTS*PRIO_W-1:0] grant_prio,
  output logic [NPORTS-1:0]        pre_v,
  output logic [NPORTS*IDX_W-1:0]  pre_in,
  output logic [NPORTS*PRIO_W-1:0] pre_prio,
  output logic [NPORTS-1:0]        in_grant,
  output logic [NPORTS-1:0]        in_wait,
  output logic [NPORTS-1:0]        nack
);
  function automatic logic [IDX_W:0] walk_chain(
    input logic [IDX_W-1:0]       start,
    input logic [NPORTS-1:0]      free,
    input logic [NPORTS-1:0]      links_on,
    input logic [NPORTS*IDX_W-1:0] links
  );
    logic [IDX_W-1:0] cur;
    logic             live;
    logic [IDX_W:0]   res;
    cur  = start;
    live = 1'b1;
    res  = '0;
    for (int k = 0; k < NPORTS; k++) begin
      if (live) begin
        if (free[cur]) begin
          res  = {1'b1, cur};
          live = 1'b0;
        end else if (links_on[cur]) begin
          cur = links[cur*IDX_W +: IDX_W];
        end else begin
          live = 1'b0;
        end
      end
    end
    return res;
  endfunction

  logic [NPORTS-1:0] free_m;
  logic [NPORTS-1:0] slot_m;
  logic [IDX_W:0]    hit;
  logic [IDX_W-1:0]  tgt;
  logic [PRIO_W-1:0] prio;

  always_comb begin
    free_m     = ~own_v;
    slot_m     = ~pend_v & ~releasing;
    grant_v    = '0;
    grant_in   = '0;
    grant_prio = '0;
    pre_v      = '0;
    pre_in     = '0;
    pre_prio   = '0;
    in_grant   = '0;
    in_wait    = '0;
    nack       = '0;
    hit        = '0;
    tgt        = '0;
    prio       = '0;
    for (int i = 0; i < NPORTS; i++) begin
      tgt  = req_port[i*IDX_W +: IDX_W];
      prio = req_prio[i*PRIO_W +: PRIO_W];
      if (req_valid[i]) begin
        if (in_busy[i]) begin
          nack[i] = 1'b1;
        end else begin
          hit = walk_chain(tgt, free_m, alt_en, alt_to);
          if (hit[IDX_W]) begin
            grant_v[hit[IDX_W-1:0]]                      = 1'b1;
            grant_in[hit[IDX_W-1:0]*IDX_W +: IDX_W]      = IDX_W'(i);
            grant_prio[hit[IDX_W-1:0]*PRIO_W +: PRIO_W]  = prio;
            free_m[hit[IDX_W-1:0]]                       = 1'b0;
            in_grant[i]                                  = 1'b1;
          end else if (own_v[tgt] && slot_m[tgt] &&
                       (prio > own_prio[tgt*PRIO_W +: PRIO_W])) begin
            pre_v[tgt]                       = 1'b1;
            pre_in[tgt*IDX_W +: IDX_W]       = IDX_W'(i);
            pre_prio[tgt*PRIO_W +: PRIO_W]   = prio;
            slot_m[tgt]                      = 1'b0;
            in_wait[i]                       = 1'b1;
          end else begin
            nack[i] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/xbar_preempt_alloc.sv
module xbar_preempt_alloc
  import xbar_alloc_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int PRIO_W = 3,
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORTS-1:0]        req_valid,
  input  logic [NPORTS*IDX_W-1:0]  req_port,
  input  logic [NPORTS*PRIO_W-1:0] req_prio,
  input  logic [NPORTS-1:0]        done_valid,
  input  logic [NPORTS-1:0]        alt_en,
  input  logic [NPORTS*IDX_W-1:0]  alt_to,
  output logic [NPORTS-1:0]        fwd_valid,
  output logic [NPORTS-1:0]        fwd_preempt,
  output logic [NPORTS*IDX_W-1:0]  fwd_src,
  output logic [NPORTS-1:0]        back_nack,
  output logic [NPORTS-1:0]        back_done
);
  logic [NPORTS-1:0]        own_v, pend_v, releasing, in_busy;
  logic [NPORTS*IDX_W-1:0]  own_in, pend_in;
  logic [NPORTS*PRIO_W-1:0] own_prio;
  logic [NPORTS-1:0]        grant_v, pre_v, in_grant, in_wait, nack;
  logic [NPORTS*IDX_W-1:0]  grant_in, pre_in;
  logic [NPORTS*PRIO_W-1:0] grant_prio, pre_prio;
  logic [NPORTS-1:0]        handoff, done_back;
  logic [NPORTS-1:0]        nx_fwd_v, nx_fwd_p;
  logic [NPORTS*IDX_W-1:0]  nx_fwd_s;
  fwd_kind_e                kind;

  assign releasing = done_valid & own_v;

  xbar_grant_logic #(.NPORTS(NPORTS), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_grant (
    .req_valid(req_valid), .req_port(req_port), .req_prio(req_prio),
    .in_busy(in_busy), .own_v(own_v), .own_prio(own_prio), .pend_v(pend_v),
    .releasing(releasing), .alt_en(alt_en), .alt_to(alt_to),
    .grant_v(grant_v), .grant_in(grant_in), .grant_prio(grant_prio),
    .pre_v(pre_v), .pre_in(pre_in), .pre_prio(pre_prio),
    .in_grant(in_grant), .in_wait(in_wait), .nack(nack)
  );

  for (genvar o = 0; o < NPORTS; o++) begin : g_port
    xbar_port_slot #(.IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_slot (
      .clk(clk), .rst(rst),
      .grant(grant_v[o]), .grant_in(grant_in[o*IDX_W +: IDX_W]),
      .grant_prio(grant_prio[o*PRIO_W +: PRIO_W]),
      .pre_set(pre_v[o]), .pre_in(pre_in[o*IDX_W +: IDX_W]),
      .pre_prio(pre_prio[o*PRIO_W +: PRIO_W]),
      .release_i(releasing[o]),
      .own_v(own_v[o]), .own_in(own_in[o*IDX_W +: IDX_W]),
      .own_prio(own_prio[o*PRIO_W +: PRIO_W]),
      .pend_v(pend_v[o]), .pend_in(pend_in[o*IDX_W +: IDX_W])
    );
  end

  for (genvar i = 0; i < NPORTS; i++) begin : g_in
    xbar_input_ctl u_ctl (
      .clk(clk), .rst(rst),
      .grant(in_grant[i]), .wait_set(in_wait[i]),
      .handoff(handoff[i]), .done_back(done_back[i]),
      .busy(in_busy[i])
    );
  end

  always_comb begin
    handoff   = '0;
    done_back = '0;
    nx_fwd_v  = '0;
    nx_fwd_p  = '0;
    nx_fwd_s  = '0;
    kind      = TOK_REQUEST;
    for (int o = 0; o < NPORTS; o++) begin
      if (releasing[o]) begin
        done_back[own_in[o*IDX_W +: IDX_W]] = 1'b1;
        if (pend_v[o]) begin
          handoff[pend_in[o*IDX_W +: IDX_W]] = 1'b1;
          nx_fwd_v[o]                        = 1'b1;
          nx_fwd_s[o*IDX_W +: IDX_W]         = pend_in[o*IDX_W +: IDX_W];
        end
      end else if (grant_v[o]) begin
        nx_fwd_v[o]                = 1'b1;
        nx_fwd_s[o*IDX_W +: IDX_W] = grant_in[o*IDX_W +: IDX_W];
      end else if (pre_v[o]) begin
        kind                       = TOK_PREEMPT;
        nx_fwd_v[o]                = 1'b1;
        nx_fwd_p[o]                = (kind == TOK_PREEMPT);
        nx_fwd_s[o*IDX_W +: IDX_W] = own_in[o*IDX_W +: IDX_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid   <= '0;
      fwd_preempt <= '0;
      fwd_src     <= '0;
      back_nack   <= '0;
      back_done   <= '0;
    end else begin
      fwd_valid   <= nx_fwd_v;
      fwd_preempt <= nx_fwd_p;
      fwd_src     <= nx_fwd_s;
      back_nack   <= nack;
      back_done   <= done_back;
    end
  end

  // R2: an input is answered by at most one of grant, wait or NACK
  a_r2_one_answer: assert property (@(posedge clk) disable iff (rst)
    $countones(in_grant & in_wait) == 0 && $countones(nack & (in_grant | in_wait)) == 0);
  // R11: a preempt token is always accompanied by a valid token
  a_r11_preempt_valid: assert property (@(posedge clk) disable iff (rst)
    (fwd_preempt & ~fwd_valid) == '0);
endmodule

// File: tb/xbar_preempt_alloc_bench.sv
module xbar_preempt_alloc_bench;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    req_valid = '0;
  logic [N*IW-1:0] req_port  = '0;
  logic [N*PW-1:0] req_prio  = '0;
  logic [N-1:0]    done_valid = '0;
  logic [N-1:0]    alt_en = '0;
  logic [N*IW-1:0] alt_to = '0;
  logic [N-1:0]    fwd_valid, fwd_preempt, back_nack, back_done;
  logic [N*IW-1:0] fwd_src;

  always #2 clk = ~clk;

  xbar_preempt_alloc #(.NPORTS(N), .PRIO_W(PW)) u_xbar_preempt_alloc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
    .req_prio(req_prio), .done_valid(done_valid), .alt_en(alt_en), .alt_to(alt_to),
    .fwd_valid(fwd_valid), .fwd_preempt(fwd_preempt), .fwd_src(fwd_src),
    .back_nack(back_nack), .back_done(back_done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural model state
  int m_ov[N], m_oi[N], m_op[N], m_pv[N], m_pi[N], m_pp[N], m_conn[N], m_wait[N];
  int e_fv[N], e_fp[N], e_fs[N], e_bn[N], e_bd[N];
  string t_f[N], t_b[N];

  task automatic model_reset();
    for (int k = 0; k < N; k++) begin
      m_ov[k] = 0; m_oi[k] = 0; m_op[k] = 0; m_pv[k] = 0; m_pi[k] = 0;
      m_pp[k] = 0; m_conn[k] = 0; m_wait[k] = 0;
      e_fv[k] = 0; e_fp[k] = 0; e_fs[k] = 0; e_bn[k] = 0; e_bd[k] = 0;
      t_f[k] = "R11"; t_b[k] = "R11";
    end
  endtask

  task automatic model_eval();
    int fr[N], ps[N], rel[N], claimed[N];
    int g_port[N], w_port[N];
    for (int k = 0; k < N; k++) begin
      e_fv[k] = 0; e_fp[k] = 0; e_fs[k] = 0; e_bn[k] = 0; e_bd[k] = 0;
      t_f[k] = "R11"; t_b[k] = "R11";
      rel[k] = (done_valid[k] && m_ov[k]) ? 1 : 0;
      fr[k] = m_ov[k] ? 0 : 1;
      ps[k] = (!m_pv[k] && !rel[k]) ? 1 : 0;
      claimed[k] = 0; g_port[k] = -1; w_port[k] = -1;
    end
    for (int o = 0; o < N; o++) if (rel[o]) begin
      e_bd[m_oi[o]] = 1; t_b[m_oi[o]] = "R4";
      if (m_pv[o]) begin e_fv[o] = 1; e_fs[o] = m_pi[o]; t_f[o] = "R7"; end
    end
    for (int i = 0; i < N; i++) if (req_valid[i]) begin
      int st, cur, found, steps, pr;
      st = int'(req_port[i*IW +: IW]);
      pr = int'(req_prio[i*PW +: PW]);
      if (m_conn[i] || m_wait[i]) begin
        e_bn[i] = 1; t_b[i] = "R9";
      end else begin
        cur = st; found = -1; steps = 0;
        while (steps < N && found < 0) begin
          if (fr[cur]) found = cur;
          else if (alt_en[cur]) cur = int'(alt_to[cur*IW +: IW]);
          else steps = N;
          steps++;
        end
        if (found >= 0) begin
          e_fv[found] = 1; e_fs[found] = i; t_f[found] = (found == st) ? "R1" : "R3";
          fr[found] = 0; claimed[found] = 1; g_port[i] = found;
        end else if (m_ov[st] && ps[st] && pr > m_op[st]) begin
          e_fv[st] = 1; e_fp[st] = 1; e_fs[st] = m_oi[st]; t_f[st] = "R5";
          ps[st] = 0; w_port[i] = st;
        end else begin
          e_bn[i] = 1;
          if (claimed[st])  t_b[i] = "R8";
          else if (rel[st]) t_b[i] = "R10";
          else if (m_ov[st]) t_b[i] = "R6";
          else t_b[i] = "R2";
        end
      end
    end
    // apply state
    for (int o = 0; o < N; o++) if (rel[o]) begin
      m_conn[m_oi[o]] = 0;
      if (m_pv[o]) begin
        m_oi[o] = m_pi[o]; m_op[o] = m_pp[o]; m_pv[o] = 0;
        m_conn[m_pi[o]] = 1; m_wait[m_pi[o]] = 0;
      end else m_ov[o] = 0;
    end
    for (int i = 0; i < N; i++) begin
      if (g_port[i] >= 0) begin
        m_ov[g_port[i]] = 1; m_oi[g_port[i]] = i;
        m_op[g_port[i]] = int'(req_prio[i*PW +: PW]); m_conn[i] = 1;
      end
      if (w_port[i] >= 0) begin
        m_pv[w_port[i]] = 1; m_pi[w_port[i]] = i;
        m_pp[w_port[i]] = int'(req_prio[i*PW +: PW]); m_wait[i] = 1;
      end
    end
  endtask

  task automatic compare();
    for (int k = 0; k < N; k++) begin
      int av, ap, as_;
      av = int'(fwd_valid[k]); ap = int'(fwd_preempt[k]); as_ = int'(fwd_src[k*IW +: IW]);
      checks++;
      if (av != e_fv[k] || (e_fv[k] && (ap != e_fp[k] || as_ != e_fs[k]))) begin
        errors++;
        $display("FAIL %s out%0d fwd: actual v=%0d p=%0d s=%0d expected v=%0d p=%0d s=%0d",
                 t_f[k], k, av, ap, as_, e_fv[k], e_fp[k], e_fs[k]);
      end
      checks++;
      if (int'(back_nack[k]) != e_bn[k] || int'(back_done[k]) != e_bd[k]) begin
        errors++;
        $display("FAIL %s in%0d back: actual nack=%0d done=%0d expected nack=%0d done=%0d",
                 t_b[k], k, back_nack[k], back_done[k], e_bn[k], e_bd[k]);
      end
    end
  endtask

  task automatic tick();
    model_eval();
    @(posedge clk); #1;
    compare();
    req_valid = '0; done_valid = '0;
  endtask

  task automatic rq(int i, int p, int pr);
    req_valid[i] = 1'b1;
    req_port[i*IW +: IW] = IW'(p);
    req_prio[i*PW +: PW] = PW'(pr);
  endtask

  task automatic link(int o, int to, bit en);
    alt_en[o] = en;
    alt_to[o*IW +: IW] = IW'(to);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    compare();                        // R11 reset state
    tick();                           // R11 idle cycle quiet
    rq(0, 2, 1); tick();              // R1 grant in0->2
    rq(1, 2, 1); tick();              // R2/R6 equal priority blocked
    link(2, 3, 1); rq(1, 2, 1); tick();// R3 alternate 2->3
    link(3, 2, 1); rq(2, 2, 0); tick();// R3 circular chain bounded, NACK
    rq(3, 2, 5); tick();              // R5 preempt holder in0
    rq(4, 2, 7); tick();              // R6 pending slot taken
    rq(0, 5, 1); rq(3, 6, 1); tick(); // R9 connected and waiting inputs
    done_valid[2] = 1'b1; rq(5, 2, 7); tick(); // R7 handoff, R10 releasing port
    done_valid[5] = 1'b1; tick();     // R4 done on unowned port ignored
    rq(5, 6, 0); rq(6, 6, 0); tick(); // R8 contention, in6 NACKed
    link(6, 7, 1); rq(6, 6, 0); rq(7, 6, 0); tick(); // R8 with alternate
    done_valid[3] = 1'b1; tick();     // R4 release in1
    rq(1, 3, 0); tick();              // R4 freed port re-granted
    for (int c = 0; c < 3000; c++) begin
      if (c % 97 == 0)
        for (int o = 0; o < N; o++) link(o, int'($urandom_range(N-1)), $urandom_range(2) != 0);
      for (int i = 0; i < N; i++)
        if ($urandom_range(3) == 0) rq(i, int'($urandom_range(N-1)), int'($urandom_range(7)));
      for (int o = 0; o < N; o++)
        done_valid[o] = ($urandom_range(5) == 0);
      tick();
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule